// File: doc/BRIEF.md
# USB Device Address Latch with Deferred Activation

This block holds the function address and the device-enable flag of a full-speed USB device controller. A microcontroller reaches it through a command/data port. A command strobe with code 0xB6 selects a write of the address register, and the next data-write strobe stores one word. A command strobe with code 0xB7 selects a read, and the register then appears on the read-back bus until a data-read strobe ends the access.

The block keeps two copies of the value. The programmed copy is the one software writes and reads back. The active copy is the one the packet engine uses for token matching. A write does not change the active copy. The firmware answers a Set Address request by writing the new value and then sending a zero-length status packet. When the host acknowledges that packet, a strobe copies the programmed value into the active copy.

A bus reset forces the active copy to address zero with the device enabled. It leaves the programmed copy untouched and cancels any update that is still waiting.

Top module: `devaddr_keeper`

## Requirements
- R1: After rst_n is deasserted, act_addr is 0, act_en is 0, and a read access returns 0.
- R2: Command code 0xB6 followed by a dat_wr_stb stores dat_in[7:0] as the programmed value and ignores the upper bits. Command code 0xB7 puts the programmed value on dat_out[7:0] with dat_out[15:8] zero, and dat_out stays zero while no read is selected.
- R3: A register write leaves act_addr and act_en unchanged until an acknowledge strobe arrives.
- R4: A status_ack pulse with an update pending loads act_en from programmed bit 7 and act_addr from programmed bits 6:0. The outputs show the new value after the clock edge on which the strobe is sampled.
- R5: A status_ack pulse with no update pending leaves act_addr and act_en unchanged.
- R6: A bus_reset pulse sets act_addr to 0 and act_en to 1 on the next edge and leaves the programmed value unchanged.
- R7: A bus_reset cancels a pending update, so a later status_ack has no effect.
- R8: If several writes arrive before the acknowledge, the value of the most recent write is the one applied.
- R9: When bus_reset and status_ack arrive in the same cycle, bus_reset wins: the active outputs become 0 and enabled, and the update is dropped.
- R10: A data-write strobe is ignored unless the write code 0xB6 selected the register. This covers a read selection and any other command code.
- R11: Programmed bit 7 is the enable flag: a value with bit 7 clear, once applied, drives act_en low while act_addr still takes bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe; cmd_code is valid |
| cmd_code | input | 8 | Command code (0xB6 write, 0xB7 read) |
| dat_wr_stb | input | 1 | Data-word write strobe |
| dat_in | input | DATA_W | Data word written by the microcontroller |
| dat_rd_stb | input | 1 | Data-word read strobe; ends a read access |
| dat_out | output | DATA_W | Read-back data |
| bus_reset | input | 1 | USB bus reset seen on the line (one-cycle pulse) |
| status_ack | input | 1 | Host acknowledged the zero-length IN status packet |
| act_addr | output | 7 | Active device address used for token matching |
| act_en | output | 1 | Active device-enable flag |

## Verification
The bench builds the block with its defaults: a 16-bit data word and the command codes 0xB6 and 0xB7. The 16-bit width means a write can carry nonzero upper bits, so the bench can show that those bits are dropped and that a read returns a zero upper byte. The fixed codes let the bench try a stray code and a read selection before a data write, and confirm that neither reaches the register.

// File: rtl/devaddr_keeper.sv
module devaddr_keeper #(
  parameter int DATA_W = 16,
  parameter logic [7:0] WR_CODE = 8'hB6,
  parameter logic [7:0] RD_CODE = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_code,
  input  logic              dat_wr_stb,
  input  logic [DATA_W-1:0] dat_in,
  input  logic              dat_rd_stb,
  output logic [DATA_W-1:0] dat_out,
  input  logic              bus_reset,
  input  logic              status_ack,
  output logic [6:0]        act_addr,
  output logic              act_en
);

  logic [7:0] prog;
  logic       pend;
  logic       sel_wr, sel_rd;
  logic       wr_fire;
  logic       unused_hi;

  assign wr_fire   = dat_wr_stb && sel_wr && !cmd_stb;
  assign unused_hi = ^dat_in[DATA_W-1:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_wr <= 1'b0;
      sel_rd <= 1'b0;
    end else if (cmd_stb) begin
      sel_wr <= (cmd_code == WR_CODE);
      sel_rd <= (cmd_code == RD_CODE);
    end else begin
      if (wr_fire)                sel_wr <= 1'b0;
      if (dat_rd_stb && sel_rd)   sel_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prog <= 8'h00;
    else if (wr_fire) prog <= dat_in[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      act_addr <= 7'd0;
      act_en   <= 1'b0;
    end else if (bus_reset) begin
      pend     <= 1'b0;
      act_addr <= 7'd0;
      act_en   <= 1'b1;
    end else begin
      if (status_ack && pend) begin
        act_addr <= prog[6:0];
        act_en   <= prog[7];
      end
      if (wr_fire)                 pend <= 1'b1;
      else if (status_ack && pend) pend <= 1'b0;
    end
  end

  always_comb begin
    dat_out = '0;
    if (sel_rd) dat_out[7:0] = prog;
  end

  a_r6_reset_forces: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (act_addr == 7'd0) && act_en);

  a_r6_prog_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !wr_fire) |=> $stable(prog));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && !status_ack) |=> ($stable(act_addr) && $stable(act_en)));

  a_r4_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ack && pend && !bus_reset) |=> ({act_en, act_addr} == $past(prog)));

  a_r5_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ack && !pend && !bus_reset) |=> ($stable(act_addr) && $stable(act_en)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dat_out[DATA_W-1:8] == '0);

endmodule

// File: tb/devaddr_keeper_tb.sv
module devaddr_keeper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        dat_wr_stb = 1'b0;
  logic [15:0] dat_in = 16'h0;
  logic        dat_rd_stb = 1'b0;
  logic [15:0] dat_out;
  logic        bus_reset = 1'b0;
  logic        status_ack = 1'b0;
  logic [6:0]  act_addr;
  logic        act_en;

  int n_chk = 0;
  int n_bad = 0;

  devaddr_keeper u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .dat_wr_stb(dat_wr_stb), .dat_in(dat_in), .dat_rd_stb(dat_rd_stb),
    .dat_out(dat_out), .bus_reset(bus_reset), .status_ack(status_ack),
    .act_addr(act_addr), .act_en(act_en)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_act(input string tag, input logic [6:0] ea, input logic ee);
    chk({tag, " addr"}, {9'd0, act_addr}, {9'd0, ea});
    chk({tag, " en"}, {15'd0, act_en}, {15'd0, ee});
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_stb = 1'b1; cmd_code = c;
    @(negedge clk); cmd_stb = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] d);
    send_cmd(8'hB6);
    dat_wr_stb = 1'b1; dat_in = d;
    @(negedge clk); dat_wr_stb = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] d);
    send_cmd(8'hB7);
    d = dat_out;
    dat_rd_stb = 1'b1;
    @(negedge clk); dat_rd_stb = 1'b0;
  endtask

  task automatic pulse(input logic rst_p, input logic ack_p);
    @(negedge clk); bus_reset = rst_p; status_ack = ack_p;
    @(negedge clk); bus_reset = 1'b0; status_ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk_act("R1 reset state", 7'd0, 1'b0);
    read_word(v);
    chk("R1 reset readback", v, 16'h0000);
    chk("R2 idle dat_out zero", dat_out, 16'h0000);
  endtask

  task automatic t_defer_apply;
    logic [15:0] v;
    write_word(16'hFF85);
    chk_act("R3 after write", 7'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk_act("R3 still deferred", 7'd0, 1'b0);
    read_word(v);
    chk("R2 readback low byte, upper zero", v, 16'h0085);
    pulse(1'b0, 1'b1);
    chk_act("R4 applied on ack", 7'h05, 1'b1);
  endtask

  task automatic t_bus_reset_and_idle_ack;
    logic [15:0] v;
    pulse(1'b1, 1'b0);
    chk_act("R6 bus reset", 7'd0, 1'b1);
    read_word(v);
    chk("R6 programmed kept", v, 16'h0085);
    pulse(1'b0, 1'b1);
    chk_act("R5 ack without pending", 7'd0, 1'b1);
  endtask

  task automatic t_reset_cancels;
    logic [15:0] v;
    write_word(16'h0023);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk_act("R7 pending cancelled", 7'd0, 1'b1);
    read_word(v);
    chk("R7 programmed value kept", v, 16'h0023);
  endtask

  task automatic t_double_write;
    write_word(16'h0040);
    write_word(16'h00C7);
    pulse(1'b0, 1'b1);
    chk_act("R8 latest write applied", 7'h47, 1'b1);
  endtask

  task automatic t_reset_vs_ack;
    write_word(16'h0099);
    pulse(1'b1, 1'b1);
    chk_act("R9 reset wins", 7'd0, 1'b1);
    pulse(1'b0, 1'b1);
    chk_act("R9 update dropped", 7'd0, 1'b1);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    send_cmd(8'hB7);
    dat_wr_stb = 1'b1; dat_in = 16'h0055;
    @(negedge clk); dat_wr_stb = 1'b0; dat_rd_stb = 1'b1;
    @(negedge clk); dat_rd_stb = 1'b0;
    send_cmd(8'h3C);
    dat_wr_stb = 1'b1; dat_in = 16'h0066;
    @(negedge clk); dat_wr_stb = 1'b0;
    read_word(v);
    chk("R10 stray writes ignored", v, 16'h0099);
    pulse(1'b0, 1'b1);
    chk_act("R10 no pending from stray", 7'd0, 1'b1);
  endtask

  task automatic t_disable;
    write_word(16'h000A);
    pulse(1'b0, 1'b1);
    chk_act("R11 enable clear applied", 7'h0A, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defer_apply();
    t_bus_reset_and_idle_ack();
    t_reset_cancels();
    t_double_write();
    t_reset_vs_ack();
    t_ignored();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule